// File: doc/BRIEF.md
# Sequential Shift-Add Multiplier with Per-Operand Signedness

This block multiplies two 8-bit operands into a 16-bit product. It builds the product one partial-product term per clock cycle into a running accumulator. Each operand has its own flag that selects whether it is read as unsigned or as two's complement. All four combinations of the flags are supported.

The caller raises `start` for one cycle with the operands and flags. The block captures them, raises `busy` for eight accumulation cycles and then pulses `done` for one cycle with the finished product on `product`.

Term i is operand b masked by bit i of operand a and shifted left by i places. When b is signed, the term is sign-extended to 16 bits before the shift. When a is signed, the term for a's top bit is subtracted from the sum rather than added.

Top module: `shift_add_mul`

## Requirements
- R1: On a rising edge where `start` is high and `busy` is low, the block captures `op_a`, `op_b`, `a_signed` and `b_signed`, clears its accumulator, and shows `busy` high from that edge onward.
- R2: While `busy` is high, `start` and changes on the operand and flag inputs have no effect on the result or on the timing of `done`.
- R3: With both flags low, `done` presents `product` equal to the unsigned product of the two operands.
- R4: With `b_signed` high and `a_signed` low, `product` equals unsigned a times two's-complement b, taken modulo 2^16.
- R5: With `a_signed` high and `b_signed` low, `product` equals two's-complement a times unsigned b, taken modulo 2^16. The term for bit 7 of a is subtracted.
- R6: With both flags high, `product` equals the signed product modulo 2^16. This includes -128 times -128, which gives 0x4000.
- R7: `busy` stays high for exactly eight cycles. `done` rises on the eighth rising edge after the capture edge, together with `busy` falling. `done` is high for exactly one cycle, and `busy` and `done` are never high together.
- R8: `product` changes only on the edge where `done` rises. It holds its value after that, including while a later operation is running.
- R9: Synchronous active-high `rst` returns the block to idle with `busy` low, `done` low and `product` zero. An operation cut off by reset never raises `done`.
- R10: A `start` presented in the same cycle that `done` is high is accepted as a new operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to begin a multiplication |
| op_a | input | 8 | Operand a, whose bits select the terms |
| op_b | input | 8 | Operand b, which forms each term |
| a_signed | input | 1 | 1 reads operand a as two's complement |
| b_signed | input | 1 | 1 reads operand b as two's complement |
| busy | output | 1 | High while terms are being accumulated |
| done | output | 1 | One-cycle pulse when the product is ready |
| product | output | 16 | Product of the last completed operation |

## Verification
The assertions assume that `start` is sampled only at rising edges. They also assume that the operands and flags are meaningful only on an accepting edge, so the reference product is captured there and nowhere else. The stimulus changes inputs only at falling edges. It drives `start` while `busy` is high only in the one scenario that checks it is ignored, and it releases reset only between clock edges. The random and corner operands cover all four flag combinations, including the most negative values in both operands.

// File: rtl/smul_pkg.sv
package smul_pkg;
    localparam int OP_W   = 8;
    localparam int PROD_W = 2 * OP_W;
    localparam int IDX_W  = $clog2(OP_W);

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } mul_state_e;

    typedef struct packed {
        logic [OP_W-1:0] a;
        logic [OP_W-1:0] b;
        logic            a_sgn;
        logic            b_sgn;
    } opnd_t;
endpackage

// File: rtl/smul_ctrl.sv
module smul_ctrl
    import smul_pkg::*;
#(
    parameter int N_TERMS = OP_W,
    localparam int IW = $clog2(N_TERMS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    output logic          accept,
    output logic          busy,
    output logic          done,
    output logic [IW-1:0] step,
    output logic          last
);
    localparam logic [IW-1:0] LAST_IDX = IW'(N_TERMS - 1);

    typedef struct packed {
        mul_state_e    st;
        logic [IW-1:0] idx;
        logic          done;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d      = ctrl_q;
        ctrl_d.done = 1'b0;
        accept      = (ctrl_q.st == ST_IDLE) && start;
        case (ctrl_q.st)
            ST_IDLE: begin
                if (start) begin
                    ctrl_d.st  = ST_RUN;
                    ctrl_d.idx = '0;
                end
            end
            ST_RUN: begin
                if (ctrl_q.idx == LAST_IDX) begin
                    ctrl_d.st   = ST_IDLE;
                    ctrl_d.done = 1'b1;
                end else begin
                    ctrl_d.idx = ctrl_q.idx + 1'b1;
                end
            end
            default: ctrl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q.st   <= ST_IDLE;
            ctrl_q.idx  <= '0;
            ctrl_q.done <= 1'b0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign busy = (ctrl_q.st == ST_RUN);
    assign done = ctrl_q.done;
    assign step = ctrl_q.idx;
    assign last = busy && (ctrl_q.idx == LAST_IDX);
endmodule

// File: rtl/smul_ppgen.sv
module smul_ppgen
    import smul_pkg::*;
(
    input  logic [OP_W-1:0]   a,
    input  logic [OP_W-1:0]   b,
    input  logic              a_sgn,
    input  logic              b_sgn,
    input  logic [IDX_W-1:0]  step,
    output logic [PROD_W-1:0] term,
    output logic              negate
);
    localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(OP_W - 1);

    logic              sel_bit;
    logic [PROD_W-1:0] b_ext;
    logic [PROD_W-1:0] masked;

    assign sel_bit = a[step];

    always_comb begin
        if (b_sgn) b_ext = {{OP_W{b[OP_W-1]}}, b};
        else       b_ext = {{OP_W{1'b0}}, b};
    end

    for (genvar g = 0; g < PROD_W; g++) begin : g_mask
        assign masked[g] = b_ext[g] & sel_bit;
    end

    assign term   = masked << step;
    assign negate = a_sgn && (step == TOP_IDX);
endmodule

// File: rtl/smul_accum.sv
module smul_accum
    import smul_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              en,
    input  logic              last,
    input  logic              negate,
    input  logic [PROD_W-1:0] term,
    output logic [PROD_W-1:0] product
);
    typedef struct packed {
        logic [PROD_W-1:0] acc;
        logic [PROD_W-1:0] prod;
    } acc_t;

    acc_t acc_d, acc_q;
    logic [PROD_W-1:0] sum;

    always_comb begin
        acc_d = acc_q;
        sum   = negate ? (acc_q.acc - term) : (acc_q.acc + term);
        if (clear) begin
            acc_d.acc = '0;
        end else if (en) begin
            acc_d.acc = sum;
            if (last) acc_d.prod = sum;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q.acc  <= '0;
            acc_q.prod <= '0;
        end else begin
            acc_q <= acc_d;
        end
    end

    assign product = acc_q.prod;
endmodule

// File: rtl/shift_add_mul.sv
module shift_add_mul
    import smul_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [OP_W-1:0]   op_a,
    input  logic [OP_W-1:0]   op_b,
    input  logic              a_signed,
    input  logic              b_signed,
    output logic              busy,
    output logic              done,
    output logic [PROD_W-1:0] product
);
    opnd_t opnd_d, opnd_q;

    logic              accept;
    logic              last;
    logic [IDX_W-1:0]  step;
    logic [PROD_W-1:0] term;
    logic              negate;

    always_comb begin
        opnd_d = opnd_q;
        if (accept) begin
            opnd_d.a     = op_a;
            opnd_d.b     = op_b;
            opnd_d.a_sgn = a_signed;
            opnd_d.b_sgn = b_signed;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) opnd_q <= '0;
        else     opnd_q <= opnd_d;
    end

    smul_ctrl #(.N_TERMS(OP_W)) u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .accept (accept),
        .busy   (busy),
        .done   (done),
        .step   (step),
        .last   (last)
    );

    smul_ppgen u_ppgen (
        .a      (opnd_q.a),
        .b      (opnd_q.b),
        .a_sgn  (opnd_q.a_sgn),
        .b_sgn  (opnd_q.b_sgn),
        .step   (step),
        .term   (term),
        .negate (negate)
    );

    smul_accum u_accum (
        .clk     (clk),
        .rst     (rst),
        .clear   (accept),
        .en      (busy),
        .last    (last),
        .negate  (negate),
        .term    (term),
        .product (product)
    );
endmodule

// File: rtl/smul_chk.sv
module smul_chk
    import smul_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic [OP_W-1:0]   op_a,
    input logic [OP_W-1:0]   op_b,
    input logic              a_signed,
    input logic              b_signed,
    input logic              busy,
    input logic              done,
    input logic [PROD_W-1:0] product
);
    logic [PROD_W-1:0] ref_q;
    logic [4:0]        run_len;
    logic              take;
    logic signed [31:0] av, bv, pv;

    assign take = start && !busy;

    always_comb begin
        av = a_signed ? 32'(signed'(op_a)) : 32'(op_a);
        bv = b_signed ? 32'(signed'(op_b)) : 32'(op_b);
        pv = av * bv;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ref_q   <= '0;
            run_len <= '0;
        end else if (take) begin
            ref_q   <= pv[PROD_W-1:0];
            run_len <= '0;
        end else if (busy && run_len != 5'd31) begin
            run_len <= run_len + 5'd1;
        end
    end

    // R1: an accepted start raises busy
    assert_busy_after_start_R1: assert property (@(posedge clk) disable iff (rst)
        take |=> busy);

    // R3 R4 R5 R6, with R2 covered by the reference being captured only on acceptance
    assert_product_matches_R3: assert property (@(posedge clk) disable iff (rst)
        done |-> product == ref_q);

    assert_run_length_R7: assert property (@(posedge clk) disable iff (rst)
        done |-> run_len == 5'd8);

    assert_done_single_R7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_no_overlap_R7: assert property (@(posedge clk) disable iff (rst)
        !(busy && done));

    assert_product_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (!done && !$past(rst)) |-> $stable(product));

    assert_reset_idle_R9: assert property (@(posedge clk)
        $past(rst) |-> (!busy && !done));
endmodule

bind shift_add_mul smul_chk u_chk (.*);

// File: tb/shift_add_mul_tb.sv
module shift_add_mul_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [7:0]  op_a = '0;
    logic [7:0]  op_b = '0;
    logic        a_signed = 1'b0;
    logic        b_signed = 1'b0;
    logic        busy;
    logic        done;
    logic [15:0] product;

    int n_checks = 0;
    int n_fails  = 0;
    logic [15:0] lfsr = 16'hACE1;

    always #(CLK_PERIOD/2) clk = ~clk;

    shift_add_mul u_dut (
        .clk(clk), .rst(rst), .start(start), .op_a(op_a), .op_b(op_b),
        .a_signed(a_signed), .b_signed(b_signed),
        .busy(busy), .done(done), .product(product)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_prod(input logic [7:0] a, input logic [7:0] b,
                                             input logic sa, input logic sb);
        int ai, bi, p;
        ai = sa ? int'(signed'(a)) : int'(a);
        bi = sb ? int'(signed'(b)) : int'(b);
        p  = ai * bi;
        return p[15:0];
    endfunction

    function automatic string mode_tag(input logic sa, input logic sb);
        if (!sa && !sb) return "R3";
        if (!sa &&  sb) return "R4";
        if ( sa && !sb) return "R5";
        return "R6";
    endfunction

    // called at a falling edge; returns at the next falling edge
    task automatic launch(input logic [7:0] a, input logic [7:0] b,
                          input logic sa, input logic sb);
        start = 1'b1; op_a = a; op_b = b; a_signed = sa; b_signed = sb;
        @(negedge clk);
        start = 1'b0;
    endtask

    // latency counts falling edges from the launch edge; done is expected at 9
    task automatic wait_done(output int lat);
        lat = 1;
        while (!done && lat < 20) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic run_op(input logic [7:0] a, input logic [7:0] b,
                          input logic sa, input logic sb);
        int lat;
        logic [15:0] e;
        e = exp_prod(a, b, sa, sb);
        launch(a, b, sa, sb);
        chk(busy === 1'b1, "R1", int'(busy), 1);
        op_a = ~a; op_b = ~b;
        wait_done(lat);
        chk(lat == 9, "R7", lat, 9);
        chk(product === e, mode_tag(sa, sb), int'(product), int'(e));
        chk(busy === 1'b0, "R7", int'(busy), 0);
        @(negedge clk);
        chk(done === 1'b0, "R7", int'(done), 0);
    endtask

    task automatic t_reset;
        chk(busy === 1'b0, "R9", int'(busy), 0);
        chk(done === 1'b0, "R9", int'(done), 0);
        chk(product === 16'h0, "R9", int'(product), 0);
    endtask

    task automatic t_corners;
        for (int m = 0; m < 4; m++) begin
            run_op(8'h80, 8'h80, m[1], m[0]);
            run_op(8'hFF, 8'hFF, m[1], m[0]);
            run_op(8'h00, 8'h9C, m[1], m[0]);
            run_op(8'h7F, 8'h80, m[1], m[0]);
            run_op(8'h80, 8'h01, m[1], m[0]);
        end
        run_op(8'h80, 8'h80, 1'b1, 1'b1);
        chk(product === 16'h4000, "R6", int'(product), 16'h4000);
    endtask

    task automatic t_random;
        for (int i = 0; i < 200; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            run_op(lfsr[7:0], lfsr[15:8], lfsr[3], lfsr[9]);
        end
    endtask

    task automatic t_ignore;
        int lat;
        logic [15:0] e;
        e = exp_prod(8'h5A, 8'hC3, 1'b1, 1'b0);
        launch(8'h5A, 8'hC3, 1'b1, 1'b0);
        @(negedge clk);
        @(negedge clk);
        start = 1'b1; op_a = 8'h11; op_b = 8'h22; a_signed = 1'b0; b_signed = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 4;
        while (!done && lat < 20) begin
            @(negedge clk);
            lat++;
        end
        chk(lat == 9, "R2", lat, 9);
        chk(product === e, "R2", int'(product), int'(e));
        @(negedge clk);
        chk(busy === 1'b0, "R2", int'(busy), 0);
    endtask

    task automatic t_hold;
        logic [15:0] held;
        int lat;
        run_op(8'h37, 8'hE9, 1'b0, 1'b1);
        held = product;
        repeat (5) @(negedge clk);
        chk(product === held, "R8", int'(product), int'(held));
        launch(8'h12, 8'h34, 1'b0, 1'b0);
        repeat (4) @(negedge clk);
        chk(product === held, "R8", int'(product), int'(held));
        wait_done(lat);
        chk(product === 16'h03A8, "R8", int'(product), 16'h03A8);
        @(negedge clk);
    endtask

    task automatic t_back2back;
        int lat;
        launch(8'hF0, 8'h0F, 1'b1, 1'b1);
        wait_done(lat);
        chk(product === exp_prod(8'hF0, 8'h0F, 1'b1, 1'b1), "R10", int'(product),
            int'(exp_prod(8'hF0, 8'h0F, 1'b1, 1'b1)));
        launch(8'h23, 8'hB7, 1'b0, 1'b1);
        chk(busy === 1'b1, "R10", int'(busy), 1);
        wait_done(lat);
        chk(lat == 9, "R10", lat, 9);
        chk(product === exp_prod(8'h23, 8'hB7, 1'b0, 1'b1), "R10", int'(product),
            int'(exp_prod(8'h23, 8'hB7, 1'b0, 1'b1)));
        @(negedge clk);
    endtask

    task automatic t_reset_mid;
        int seen;
        launch(8'h44, 8'h55, 1'b0, 1'b0);
        repeat (3) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(busy === 1'b0, "R9", int'(busy), 0);
        chk(done === 1'b0, "R9", int'(done), 0);
        chk(product === 16'h0, "R9", int'(product), 0);
        seen = 0;
        repeat (12) begin
            @(negedge clk);
            if (done) seen++;
        end
        chk(seen == 0, "R9", seen, 0);
    endtask

    task automatic finish_run;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_corners();
        t_random();
        t_ignore();
        t_hold();
        t_back2back();
        t_reset_mid();
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        finish_run();
    end
endmodule